// File: doc/BRIEF.md
# Power-Management Event Status and Enable Unit

This block records wake and interrupt requests for the always-on power domain. Eight event sources can set a status flag: a power-management request from an add-in card, an external system-management request, an SMBus alert, a USB resume, a thermal alarm, a thermal override, and two general-purpose inputs, one from the standby well and one from the core well. Software reads the flags and enables through a small register bus and clears a flag by writing a one to it. When any flag is set and its enable is set, a single combined event output is raised. That output is used as the request for SCI, SMI and wake.

The thermal alarm input has a selectable active level. A long-duration timer counts slow standby ticks while the alarm stays active. When the count completes, the timer raises a throttle request and sets the override flag. The unit has only one reset, the standby-well reset. System power-good and platform reset do not reach it, so every flag and enable survives them.

Top module: `pm_event_unit`

## Requirements
- R1: The status register is at byte offset 0x14 and the enable register is at 0x16. A read at any other offset returns 0. Bits 4, 7 and 15:10 of both registers always read 0, even after a write of all ones.
- R2: The status bit positions are: 0 card power request, 1 external SMI, 2 SMBus alert, 3 USB resume, 5 thermal, 6 thermal override, 8 standby general-purpose input, 9 core general-purpose input. A non-thermal source sets its bit on a 0-to-1 change between two consecutive clock samples. A source that stays high does not set the bit again. The new bit is visible after that clock edge.
- R3: Writing the status offset clears each bit whose write-data bit is 1. Bits whose write-data bit is 0 keep their value.
- R4: If a source sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R5: The enable bits are plain read/write storage, cleared by reset. They change only when the enable offset is written.
- R6: `pm_event` is 1 exactly when some status bit and its matching enable bit are both 1.
- R7: The thermal input counts as active when it is high with `therm_act_high`=1, or when it is low with `therm_act_high`=0. Status bit 5 sets when the input becomes active.
- R8: After HOLD_TICKS `slow_tick` pulses during one unbroken active period of the thermal input, `throttle_on` rises and status bit 6 sets, both after the clock edge of the last counted tick. Any inactive cycle restarts the count from zero.
- R9: `throttle_on` stays high until the thermal input goes inactive, then falls after the next clock edge. Bit 6 sets at most once per active period.
- R10: The standby reset `rst_sby_n` (asynchronous, active low) clears all status bits, all enable bits, the count and `throttle_on`. No other input resets the unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby-domain clock |
| rst_sby_n | input | 1 | Standby-well reset, async, active low |
| slow_tick | input | 1 | One-cycle pulse of the slow time base |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the addressed register |
| src_pme | input | 1 | Add-in card power request, active high |
| src_ext_smi | input | 1 | External SMI request, active high |
| src_smb_alert | input | 1 | SMBus alert, active high |
| src_usb_resume | input | 1 | USB resume indication, active high |
| src_gpi_sby | input | 1 | Standby-well general-purpose input |
| src_gpi_core | input | 1 | Core-well general-purpose input |
| therm_in | input | 1 | Thermal alarm level |
| therm_act_high | input | 1 | Active level select for therm_in |
| pm_event | output | 1 | Combined SCI/SMI/wake request |
| throttle_on | output | 1 | Throttle request from the override timer |

## Verification
Several rules are checked by assertions on every cycle. A write-one-to-clear never leaves a cleared bit set unless a set coincides with it. A set always lands. The enable register holds unless it is written. `pm_event` rises only after a set or an enable write. The count returns to zero whenever the thermal input is inactive, and `throttle_on` falls one edge after the alarm ends. Other rules can only be shown by the bench scenarios: the exact bit map, reserved bits reading zero, the tick at which the override fires, the restart of the count after a short dropout, the inverted polarity, and recovery from a standby reset with live state.

// File: rtl/pm_event_pkg.sv
package pm_event_pkg;

    localparam int unsigned PM_REG_W = 16;

    // status bit positions, shared by capture, timer and register file
    localparam int unsigned BIT_OVR  = 6;

    // implemented bits: 0,1,2,3,5,6,8,9
    localparam logic [PM_REG_W-1:0] IMPL_MASK = 16'h036F;

    // source vector order used inside the block
    localparam int unsigned NSRC      = 7;
    localparam int unsigned SRC_THERM = 4;
    localparam int unsigned SRC_POS [NSRC] = '{0, 1, 2, 3, 5, 8, 9};

    typedef logic [PM_REG_W-1:0] pm_word_t;

    typedef struct packed {
        pm_word_t sta;
        pm_word_t en;
    } pm_regs_t;

endpackage

// File: rtl/pm_event_capture.sv
module pm_event_capture
    import pm_event_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] raw_i,
    input  logic            therm_act_high_i,
    output logic            therm_act_o,
    output pm_word_t        set_o
);

    typedef struct packed {
        logic [NSRC-1:0] prev;
    } cap_st_t;

    cap_st_t         cap_d, cap_q;
    logic [NSRC-1:0] lvl;
    logic [NSRC-1:0] rise;

    // per-source active level; the thermal lane gets the polarity select
    for (genvar i = 0; i < NSRC; i++) begin : g_lvl
        if (i == SRC_THERM) begin : g_pol
            assign lvl[i] = raw_i[i] ~^ therm_act_high_i;
        end else begin : g_plain
            assign lvl[i] = raw_i[i];
        end
    end

    assign rise        = lvl & ~cap_q.prev;
    assign therm_act_o = lvl[SRC_THERM];

    always_comb begin
        cap_d      = cap_q;
        cap_d.prev = lvl;
        set_o      = '0;
        for (int i = 0; i < NSRC; i++) begin
            set_o[SRC_POS[i]] = rise[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    // R2: a held level produces no second set
    p_no_reset_on_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl[0] && $past(lvl[0])) |-> !set_o[SRC_POS[0]]);

endmodule

// File: rtl/pm_override_timer.sv
module pm_override_timer #(
    parameter int unsigned HOLD_TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic tick_i,
    output logic fire_o,
    output logic thr_o
);

    localparam int unsigned CW = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          thr;
    } tmr_st_t;

    tmr_st_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        fire_o = 1'b0;
        if (!act_i) begin
            tmr_d.cnt = '0;
            tmr_d.thr = 1'b0;
        end else if (!tmr_q.thr && tick_i) begin
            if (tmr_q.cnt == LAST) begin
                fire_o    = 1'b1;
                tmr_d.thr = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign thr_o = tmr_q.thr;

    // R9: throttle ends one edge after the alarm goes away
    p_thr_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.thr && !act_i) |=> !tmr_q.thr);

    // R8: an inactive cycle restarts the count
    p_cnt_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !act_i |=> (tmr_q.cnt == '0));

    // R8: throttle starts only on a counted tick while active
    p_thr_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_q.thr) |-> $past(act_i && tick_i));

endmodule

// File: rtl/pm_event_regs.sv
module pm_event_regs
    import pm_event_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned STA_OFS = 'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  pm_word_t          bus_wdata,
    output pm_word_t          bus_rdata,
    input  pm_word_t          edge_set_i,
    input  logic              ovr_set_i,
    output logic              event_o
);

    localparam logic [ADDR_W-1:0] A_STA = ADDR_W'(STA_OFS);
    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(STA_OFS + 2);

    pm_regs_t reg_d, reg_q;
    pm_word_t set_all;
    pm_word_t clr;
    logic     wr_sta, wr_en;

    always_comb begin
        set_all          = edge_set_i;
        set_all[BIT_OVR] = edge_set_i[BIT_OVR] | ovr_set_i;
        set_all          = set_all & IMPL_MASK;

        wr_sta = bus_sel && bus_wr && (bus_addr == A_STA);
        wr_en  = bus_sel && bus_wr && (bus_addr == A_EN);
        clr    = wr_sta ? bus_wdata : '0;

        reg_d     = reg_q;
        // set after clear: a coincident hardware event wins
        reg_d.sta = ((reg_q.sta & ~clr) | set_all) & IMPL_MASK;
        if (wr_en) reg_d.en = bus_wdata & IMPL_MASK;

        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == A_STA)     bus_rdata = reg_q.sta;
            else if (bus_addr == A_EN) bus_rdata = reg_q.en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign event_o = |(reg_q.sta & reg_q.en);

    // R3: a written one clears its bit when nothing sets it
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sta && ((bus_wdata & set_all) == '0)) |=> ((reg_q.sta & $past(bus_wdata)) == '0));

    // R4: every set lands, even against a clear
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_all) |=> ((reg_q.sta & $past(set_all)) == $past(set_all)));

    // R5: enable holds unless written
    p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(reg_q.en));

    // R6: the request rises only after a set or an enable write
    p_evt_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(event_o) |-> $past((|set_all) || wr_en));

endmodule

// File: rtl/pm_event_unit.sv
module pm_event_unit
    import pm_event_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned STA_OFS    = 'h14,
    parameter int unsigned HOLD_TICKS = 64
) (
    input  logic              clk,
    input  logic              rst_sby_n,
    input  logic              slow_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              src_pme,
    input  logic              src_ext_smi,
    input  logic              src_smb_alert,
    input  logic              src_usb_resume,
    input  logic              src_gpi_sby,
    input  logic              src_gpi_core,
    input  logic              therm_in,
    input  logic              therm_act_high,
    output logic              pm_event,
    output logic              throttle_on
);

    logic [NSRC-1:0] raw;
    pm_word_t        edge_set;
    logic            therm_act;
    logic            ovr_fire;

    // order must follow SRC_POS in the package
    assign raw = {src_gpi_core, src_gpi_sby, therm_in, src_usb_resume,
                  src_smb_alert, src_ext_smi, src_pme};

    pm_event_capture u_capture (
        .clk              (clk),
        .rst_n            (rst_sby_n),
        .raw_i            (raw),
        .therm_act_high_i (therm_act_high),
        .therm_act_o      (therm_act),
        .set_o            (edge_set)
    );

    pm_override_timer #(
        .HOLD_TICKS (HOLD_TICKS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_sby_n),
        .act_i  (therm_act),
        .tick_i (slow_tick),
        .fire_o (ovr_fire),
        .thr_o  (throttle_on)
    );

    pm_event_regs #(
        .ADDR_W  (ADDR_W),
        .STA_OFS (STA_OFS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_sby_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .edge_set_i (edge_set),
        .ovr_set_i  (ovr_fire),
        .event_o    (pm_event)
    );

endmodule

// File: tb/pm_event_unit_bench.sv
`timescale 1ns/1ps
module pm_event_unit_bench;

    localparam int unsigned HOLD = 8;
    localparam logic [7:0] A_STA = 8'h14;
    localparam logic [7:0] A_EN  = 8'h16;

    logic        clk = 1'b0;
    logic        rst_sby_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [6:0]  src_v = '0;   // 0 pme,1 xsmi,2 smb,3 usb,4 gpi_sby,5 gpi_core
    logic        therm_in = 1'b0, therm_act_high = 1'b1;
    logic        pm_event, throttle_on;

    int checks = 0, errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    pm_event_unit #(.HOLD_TICKS(HOLD)) u_pm_event_unit (
        .clk(clk), .rst_sby_n(rst_sby_n), .slow_tick(slow_tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_pme(src_v[0]), .src_ext_smi(src_v[1]), .src_smb_alert(src_v[2]),
        .src_usb_resume(src_v[3]), .src_gpi_sby(src_v[4]), .src_gpi_core(src_v[5]),
        .therm_in(therm_in), .therm_act_high(therm_act_high),
        .pm_event(pm_event), .throttle_on(throttle_on)
    );

    // scoreboard item: kind 0 = read data, 1 = pm_event, 2 = throttle_on
    typedef struct {
        int          kind;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    item_t mon_it;
    logic [15:0] act_v;

    always @(negedge clk) begin
        #1;
        while (sb.size() > 0) begin
            mon_it = sb.pop_front();
            case (mon_it.kind)
                0:       act_v = bus_rdata;
                1:       act_v = {15'b0, pm_event};
                default: act_v = {15'b0, throttle_on};
            endcase
            checks++;
            if (act_v !== mon_it.exp) begin
                errors++;
                $display("FAIL %s: actual=%h expected=%h", mon_it.tag, act_v, mon_it.exp);
            end
        end
    end

    task automatic expect_rd(input logic [7:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        sb.push_back('{0, e, tag});
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic expect_sig(input int kind, input logic e, input string tag);
        @(negedge clk);
        sb.push_back('{kind, {15'b0, e}, tag});
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic pulse(input int s);
        @(negedge clk); src_v[s] = 1'b1;
        @(negedge clk); src_v[s] = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_sby_n = 1'b1;

        // R10 / R5 reset state
        expect_rd(A_STA, 16'h0000, "R10 status after reset");
        expect_rd(A_EN,  16'h0000, "R5 enable after reset");
        expect_sig(1, 1'b0, "R6 event after reset");
        expect_sig(2, 1'b0, "R8 throttle after reset");

        // R2 bit map
        pulse(0); expect_rd(A_STA, 16'h0001, "R2 card request bit 0");
        pulse(1); expect_rd(A_STA, 16'h0003, "R2 ext smi bit 1");
        pulse(2); expect_rd(A_STA, 16'h0007, "R2 smbus bit 2");
        pulse(3); expect_rd(A_STA, 16'h000F, "R2 usb bit 3");
        pulse(4); expect_rd(A_STA, 16'h010F, "R2 gpi standby bit 8");
        pulse(5); expect_rd(A_STA, 16'h030F, "R2 gpi core bit 9");

        // R2 held level does not re-set after clear
        @(negedge clk); src_v[3] = 1'b1;
        wr(A_STA, 16'h0008);
        expect_rd(A_STA, 16'h0307, "R2 held usb no re-set");
        @(negedge clk); src_v[3] = 1'b0;
        expect_rd(A_STA, 16'h0307, "R2 usb release no set");

        // R3 write-one-to-clear
        wr(A_STA, 16'h0000); expect_rd(A_STA, 16'h0307, "R3 zero write keeps");
        wr(A_STA, 16'h0102); expect_rd(A_STA, 16'h0205, "R3 partial clear");
        wr(A_STA, 16'hFFFF); expect_rd(A_STA, 16'h0000, "R3 full clear");

        // R1 / R5 map and reserved bits
        wr(A_EN, 16'hFFFF);
        expect_rd(A_EN, 16'h036F, "R1 reserved enable bits zero");
        expect_rd(8'h18, 16'h0000, "R1 unmapped offset");
        expect_rd(A_STA, 16'h0000, "R1 status untouched by enable write");

        // R6 event combination
        wr(A_EN, 16'h0001);
        expect_rd(A_EN, 16'h0001, "R5 enable write");
        expect_sig(1, 1'b0, "R6 no status");
        pulse(2); expect_sig(1, 1'b0, "R6 disabled bit");
        pulse(0); expect_sig(1, 1'b1, "R6 enabled bit set");
        wr(A_EN, 16'h0000); expect_sig(1, 1'b0, "R6 enable removed");
        wr(A_EN, 16'h0004); expect_sig(1, 1'b1, "R6 other bit enabled");
        wr(A_STA, 16'h0004); expect_sig(1, 1'b0, "R6 status cleared");
        expect_rd(A_STA, 16'h0001, "R3 only smbus cleared");

        // R4 set beats clear
        @(negedge clk);
        src_v[0] = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STA; bus_wdata = 16'h0001;
        @(negedge clk);
        src_v[0] = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        expect_rd(A_STA, 16'h0001, "R4 set wins");
        wr(A_STA, 16'h0001); expect_rd(A_STA, 16'h0000, "R3 clear after R4");

        // R7 / R8 / R9 active-high alarm
        @(negedge clk); therm_in = 1'b1;
        expect_rd(A_STA, 16'h0020, "R7 thermal bit 5 active high");
        ticks(HOLD - 1);
        expect_sig(2, 1'b0, "R8 no throttle before last tick");
        expect_rd(A_STA, 16'h0020, "R8 no override early");
        ticks(1);
        expect_sig(2, 1'b1, "R8 throttle on last tick");
        expect_rd(A_STA, 16'h0060, "R8 override bit 6");
        wr(A_STA, 16'h0040);
        ticks(HOLD);
        expect_rd(A_STA, 16'h0020, "R9 override once per period");
        expect_sig(2, 1'b1, "R9 throttle held");
        @(negedge clk); therm_in = 1'b0;
        expect_sig(2, 1'b0, "R9 throttle drops");

        // R8 restart after dropout
        wr(A_STA, 16'h0020);
        @(negedge clk); therm_in = 1'b1;
        ticks(5);
        @(negedge clk); therm_in = 1'b0;
        @(negedge clk); therm_in = 1'b1;
        ticks(5);
        expect_sig(2, 1'b0, "R8 count restarted");
        ticks(HOLD - 5);
        expect_sig(2, 1'b1, "R8 fires after full run");
        @(negedge clk); therm_in = 1'b0;
        wr(A_STA, 16'hFFFF);
        expect_rd(A_STA, 16'h0000, "R3 clear before polarity");

        // R7 active-low alarm
        @(negedge clk); therm_in = 1'b1; therm_act_high = 1'b0;
        expect_rd(A_STA, 16'h0000, "R7 high level inactive");
        @(negedge clk); therm_in = 1'b0;
        expect_rd(A_STA, 16'h0020, "R7 low level active");
        ticks(HOLD);
        expect_sig(2, 1'b1, "R7 low active throttles");
        @(negedge clk); therm_in = 1'b1;
        expect_sig(2, 1'b0, "R7 high ends throttle");
        @(negedge clk); therm_in = 1'b0; therm_act_high = 1'b1;

        // R10 standby reset with live state
        wr(A_EN, 16'h036F);
        pulse(5);
        expect_rd(A_STA, 16'h0260, "R2 gpi core with thermal bits");
        expect_sig(1, 1'b1, "R6 event before reset");
        @(negedge clk); rst_sby_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_sby_n = 1'b1;
        expect_rd(A_STA, 16'h0000, "R10 status cleared");
        expect_rd(A_EN,  16'h0000, "R10 enable cleared");
        expect_sig(1, 1'b0, "R10 event cleared");
        expect_sig(2, 1'b0, "R10 throttle cleared");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (R1..R10 run): actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule